// File: doc/BRIEF.md
# Packed BCD Adjust Unit

This unit corrects a byte after a plain binary addition or subtraction of two packed-decimal operands, so that both nibbles are valid decimal digits again. It takes the raw byte, the carry and half-carry flags that the binary operation produced, and a direction select. It returns the corrected byte with a new set of status flags: carry, half-carry, sign, zero, even parity and overflow.

The low-digit step and the high-digit step both test the byte as it was before adjustment, together with the incoming flags. The high step works on the value the low step has already corrected. The low step computes a carry of its own. That carry reaches the output only when the high step stays idle; if the high step fires, the output carry is forced to 1. The unit either registers its results on a valid strobe or, with a parameter, drives them combinationally.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The low-digit step fires when the low nibble (bits 3:0) of the incoming byte is above 9 or `in_af` is 1. It then moves the byte by 0x06, up when `in_sub`=0 and down when `in_sub`=1. `out_af` equals 1 exactly when this step fires.
- R2: With `in_sub`=0, if the low step fires and the high step does not, `out_cf` is 1 when the incoming byte is above 0xF9 or `in_cf` is 1, and 0 otherwise.
- R3: With `in_sub`=1, if the low step fires and the high step does not, `out_cf` is 1 when the incoming byte is below 0x06 or `in_cf` is 1, and 0 otherwise.
- R4: The high-digit step fires when the unadjusted incoming byte is above 0x99 or `in_cf` is 1. It moves the low-corrected byte by 0x60 in the selected direction, modulo 256, and forces `out_cf` to 1.
- R5: When neither step fires, `out_byte` equals the incoming byte and `out_cf` and `out_af` are both 0.
- R6: `out_sf` equals bit 7 of `out_byte`, and `out_zf` is 1 exactly when `out_byte` is 0x00.
- R7: `out_pf` is 1 when `out_byte` holds an even number of one bits.
- R8: `out_of` is always 0.
- R9: With REGISTERED=1, all outputs take the result for the inputs one clock after a cycle with `in_valid`=1. In cycles with `in_valid`=0 they keep their values, whatever the other inputs do.
- R10: A synchronous active-high `rst` clears every output to 0 at the next clock edge, and it overrides `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for the inputs |
| in_byte | input | 8 | Raw byte from the binary add or subtract |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming half-carry flag |
| in_sub | input | 1 | 0 = adjust after add, 1 = adjust after subtract |
| out_byte | output | 8 | Corrected byte |
| out_cf | output | 1 | Carry out |
| out_af | output | 1 | Half-carry out |
| out_sf | output | 1 | Sign of the result |
| out_zf | output | 1 | Result is zero |
| out_pf | output | 1 | Even parity of the result |
| out_of | output | 1 | Overflow, always cleared |

## Verification
The bench builds the unit with its defaults: BYTE_W=8 and REGISTERED=1. An 8-bit byte keeps the full product of 256 byte values, four flag pairs and two directions at 2048 vectors, so every one of them is applied and compared. The registered build also brings the one-cycle load, the hold while the strobe is low and the reset priority within reach of the bench and of the bound checker. The combinational variant is not built by this bench.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  // Result bundle carried from the datapath into the output stage.
  typedef struct packed {
    logic [7:0] val;
    logic       cf;
    logic       af;
    logic       sf;
    logic       zf;
    logic       pf;
    logic       of;
  } adj_res_t;

  localparam int unsigned DIGIT_MAX = 9;
  localparam int unsigned DIGIT_FIX = 6;

endpackage

// File: rtl/bcd_low_fix.sv
module bcd_low_fix #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] orig,
  input  logic              af_in,
  input  logic              cf_in,
  input  logic              sub,
  output logic              fire,
  output logic [BYTE_W-1:0] fixed,
  output logic              pcarry
);
  import bcd_adj_pkg::*;

  localparam int unsigned NIB_W = BYTE_W / 2;
  localparam logic [NIB_W-1:0]  NIB_LIM  = NIB_W'(DIGIT_MAX);
  localparam logic [BYTE_W-1:0] STEP     = BYTE_W'(DIGIT_FIX);
  localparam logic [BYTE_W-1:0] ADD_EDGE = BYTE_W'((1 << BYTE_W) - 1 - DIGIT_FIX);

  logic carry_add, carry_sub;

  // Borrow or carry the +/-6 step would produce out of the byte.
  assign carry_add = (orig > ADD_EDGE) | cf_in;
  assign carry_sub = (orig < STEP) | cf_in;

  always_comb begin
    fire   = (orig[NIB_W-1:0] > NIB_LIM) | af_in;
    fixed  = orig;
    pcarry = 1'b0;
    if (fire) begin
      fixed  = sub ? (orig - STEP) : (orig + STEP);
      pcarry = sub ? carry_sub : carry_add;
    end
  end

endmodule

// File: rtl/bcd_high_fix.sv
module bcd_high_fix #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] orig,
  input  logic              cf_in,
  input  logic              sub,
  input  logic [BYTE_W-1:0] lo_fixed,
  input  logic              lo_carry,
  output logic [BYTE_W-1:0] result,
  output logic              carry
);
  import bcd_adj_pkg::*;

  localparam int unsigned NIB_W = BYTE_W / 2;
  localparam logic [BYTE_W-1:0] HI_LIM  = BYTE_W'((DIGIT_MAX << NIB_W) | DIGIT_MAX);
  localparam logic [BYTE_W-1:0] HI_STEP = BYTE_W'(DIGIT_FIX << NIB_W);

  logic fire;

  // Decision taken on the unadjusted byte, applied to the low-fixed one.
  assign fire = (orig > HI_LIM) | cf_in;

  always_comb begin
    result = lo_fixed;
    carry  = lo_carry;
    if (fire) begin
      result = sub ? (lo_fixed - HI_STEP) : (lo_fixed + HI_STEP);
      carry  = 1'b1;
    end
  end

endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] value,
  output logic              sf,
  output logic              zf,
  output logic              pf
);
  assign sf = value[BYTE_W-1];
  assign zf = (value == '0);
  assign pf = ~(^value[7:0]);
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
  parameter int unsigned BYTE_W     = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_cf,
  input  logic              in_af,
  input  logic              in_sub,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_cf,
  output logic              out_af,
  output logic              out_sf,
  output logic              out_zf,
  output logic              out_pf,
  output logic              out_of
);
  import bcd_adj_pkg::*;

  logic              lo_fire, lo_carry, hi_carry;
  logic [BYTE_W-1:0] lo_val, hi_val;
  logic              f_sf, f_zf, f_pf;
  adj_res_t          nxt, cur;

  bcd_low_fix #(.BYTE_W(BYTE_W)) u_low (
    .orig(in_byte), .af_in(in_af), .cf_in(in_cf), .sub(in_sub),
    .fire(lo_fire), .fixed(lo_val), .pcarry(lo_carry)
  );

  bcd_high_fix #(.BYTE_W(BYTE_W)) u_high (
    .orig(in_byte), .cf_in(in_cf), .sub(in_sub),
    .lo_fixed(lo_val), .lo_carry(lo_carry),
    .result(hi_val), .carry(hi_carry)
  );

  bcd_flag_gen #(.BYTE_W(BYTE_W)) u_flags (
    .value(hi_val), .sf(f_sf), .zf(f_zf), .pf(f_pf)
  );

  always_comb begin
    nxt     = '0;
    nxt.val = 8'(hi_val);
    nxt.cf  = hi_carry;
    nxt.af  = lo_fire;
    nxt.sf  = f_sf;
    nxt.zf  = f_zf;
    nxt.pf  = f_pf;
    nxt.of  = 1'b0;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)           cur <= '0;
        else if (in_valid) cur <= nxt;
      end
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign out_byte = BYTE_W'(cur.val);
  assign out_cf   = cur.cf;
  assign out_af   = cur.af;
  assign out_sf   = cur.sf;
  assign out_zf   = cur.zf;
  assign out_pf   = cur.pf;
  assign out_of   = cur.of;

endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk #(
  parameter int unsigned BYTE_W     = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_cf,
  input logic              in_af,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_cf,
  input logic              out_af,
  input logic              out_sf,
  input logic              out_zf,
  input logic              out_pf,
  input logic              out_of
);
  logic loaded;

  always_ff @(posedge clk) begin
    if (rst)           loaded <= 1'b0;
    else if (in_valid) loaded <= 1'b1;
  end

  generate
    if (REGISTERED) begin : g_props
      // R1
      low_af_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_af == (($past(in_byte[3:0]) > 4'd9) || $past(in_af))));

      // R4
      high_cf_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((in_byte > 8'h99) || in_cf)) |=> out_cf);

      // R5
      passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_byte[3:0] <= 4'd9) && !in_af && (in_byte <= 8'h99) && !in_cf)
        |=> (!out_cf && !out_af && (out_byte == $past(in_byte))));

      // R6
      zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        loaded |-> (out_zf == (out_byte == '0)));

      // R8
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        loaded |-> !out_of);

      // R9
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_byte) && $stable(out_cf) && $stable(out_af)
                       && $stable(out_pf) && $stable(out_sf)));

      // R10
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_byte == '0 && !out_cf && !out_af && !out_sf && !out_zf && !out_pf));
    end
  endgenerate

endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk #(.BYTE_W(BYTE_W), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .in_cf(in_cf), .in_af(in_af), .out_byte(out_byte), .out_cf(out_cf),
  .out_af(out_af), .out_sf(out_sf), .out_zf(out_zf), .out_pf(out_pf),
  .out_of(out_of)
);

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_cf = 1'b0, in_af = 1'b0, in_sub = 1'b0;
  logic [7:0] out_byte;
  logic       out_cf, out_af, out_sf, out_zf, out_pf, out_of;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  bcd_adjust_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_cf(in_cf), .in_af(in_af), .in_sub(in_sub),
    .out_byte(out_byte), .out_cf(out_cf), .out_af(out_af),
    .out_sf(out_sf), .out_zf(out_zf), .out_pf(out_pf), .out_of(out_of)
  );

  // Expected {byte, cf, af} from the requirement text.
  function automatic logic [9:0] model(input logic [7:0] b, input logic cf,
                                       input logic af, input logic sub);
    logic [7:0] r;
    logic       c, a;
    r = b; c = 1'b0; a = 1'b0;
    if ((b[3:0] > 4'd9) || af) begin
      a = 1'b1;
      if (sub) begin r = b - 8'h06; c = (b < 8'h06) || cf; end
      else     begin r = b + 8'h06; c = (b > 8'hF9) || cf; end
    end
    if ((b > 8'h99) || cf) begin
      r = sub ? r - 8'h60 : r + 8'h60;
      c = 1'b1;
    end
    return {r, c, a};
  endfunction

  function automatic logic even_ones(input logic [7:0] v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += int'(v[k]);
    return (n % 2) == 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] b, input logic cf, input logic af, input logic sub);
    in_byte = b; in_cf = cf; in_af = af; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic verify(input logic [7:0] b, input logic cf, input logic af, input logic sub);
    logic [9:0] e;
    logic lo, hi;
    e  = model(b, cf, af, sub);
    lo = (b[3:0] > 4'd9) || af;
    hi = (b > 8'h99) || cf;
    if (!lo && !hi) begin
      check("R5 byte", 32'(out_byte), 32'(b));
      check("R5 cf", 32'(out_cf), 32'd0);
    end else if (hi) begin
      check("R4 byte", 32'(out_byte), 32'(e[9:2]));
      check("R4 cf", 32'(out_cf), 32'd1);
    end else if (sub) begin
      check("R3 byte/cf", 32'({out_byte, out_cf}), 32'(e[9:1]));
    end else begin
      check("R2 byte/cf", 32'({out_byte, out_cf}), 32'(e[9:1]));
    end
    check("R1 af", 32'(out_af), 32'(e[0]));
    check("R6 sf/zf", 32'({out_sf, out_zf}), 32'({e[9], e[9:2] == 8'h00}));
    check("R7 pf", 32'(out_pf), 32'(even_ones(e[9:2])));
    check("R8 of", 32'(out_of), 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    logic [7:0] b;
    logic       c, a, s;
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10 reset", 32'({out_byte, out_cf, out_af, out_sf, out_zf, out_pf, out_of}), 32'd0);
    rst = 1'b0;

    // Directed corners, then the full sweep (R1..R8, R9 load timing).
    load(8'h9A, 1'b0, 1'b0, 1'b0); verify(8'h9A, 1'b0, 1'b0, 1'b0);
    load(8'h00, 1'b0, 1'b1, 1'b1); verify(8'h00, 1'b0, 1'b1, 1'b1);
    load(8'hFA, 1'b0, 1'b0, 1'b0); verify(8'hFA, 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 2048; v++) begin
      b = v[7:0]; c = v[8]; a = v[9]; s = v[10];
      load(b, c, a, s);
      verify(b, c, a, s);
    end

    // R9: random stimulus with the strobe low must not disturb outputs.
    for (int t = 0; t < 300; t++) begin
      b = 8'($urandom); c = 1'($urandom); a = 1'($urandom); s = 1'($urandom);
      load(b, c, a, s);
      held = {out_byte, out_cf, out_af};
      in_byte = 8'($urandom); in_cf = 1'($urandom); in_af = 1'($urandom);
      in_sub = 1'($urandom);
      repeat (2) @(negedge clk);
      check("R9 hold", 32'({out_byte, out_cf, out_af}), 32'(held));
      verify(b, c, a, s);
    end

    // R10: reset wins over a simultaneous valid strobe.
    load(8'hFF, 1'b1, 1'b1, 1'b0);
    rst = 1'b1; in_valid = 1'b1; in_byte = 8'h55;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R10 reset over valid",
          32'({out_byte, out_cf, out_af, out_sf, out_zf, out_pf, out_of}), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule